// File: doc/BRIEF.md
# Banked Memory Mapper with Control Ports

This block sits beside an 8-bit main processor. It decodes every memory cycle into one physical target: a row-strobe enable for one of four DRAM blocks plus three mapped upper address bits, a boot ROM select, one of four BASIC ROM selects, one of four slot ROM selects, or the select for the RAM shared with the sub-processor. A two-bit system state picks one of four memory maps. Two bank fields steer the C000h-FFFFh and 2000h-3FFFh windows, and two overlay enables hide the base RAM under the 4000h-7FFFh and 8000h-BFFFh ranges.

The same block owns four I/O ports at FCh-FFh. Two of them hold the mapping fields and drive the sub-processor reset and bus-request lines. The other two read back the configuration switches and the synchronized sub-processor handshake and interrupt status. It also marks the first clock of each opcode fetch for a single wait state, and it drives a row/column address phase strobe for the DRAM.

Top module: `bank_mapper`

## Requirements
- R1: An I/O access (iorq with rd or wr) whose low address byte is FCh-FFh raises port_sel one clock later. A write to any other low byte changes no control register.
- R2: After reset, sub_rst is 1, sub_req is 0, ports FCh and FDh read 00h, every memory select is 0, wait_drive is 0 and row_phase is 1.
- R3: Port FDh holds the state byte: bit 7 is run, bits 5:4 are the system state (0 boot, 1 all-RAM, 2 ROM BASIC, 3 RAM BASIC), and bits 3:0 are the high-window bank. sub_rst equals the inverse of bit 7, so writing 80h releases the sub-processor. The port reads back the byte written.
- R4: Port FCh holds the window byte: bit 1 drives sub_req, bit 2 is the low overlay, bit 3 is the high overlay, and bits 6:4 are the 2000h-window select. Writing 02h raises sub_req.
- R5: In every state, a memory access to F800h-FFFFh asserts only com_sel.
- R6: In state 0, 0000h-1FFFh asserts only rom_ipl. In any other state that window goes to DRAM block 0.
- R7: C000h-F7FFh selects DRAM block bank[3:2] with dram_ar = {bank[1:0], A13}.
- R8: In the 2000h window, with sel = FCh bits 6:4: in state 2, sel<4 asserts rom_basic[sel[1:0]] and sel>=4 asserts rom_slot[sel[1:0]]. In state 3, sel>=4 asserts rom_slot[sel[1:0]] and sel<4 gives DRAM block 0. In states 0 and 1 it always gives DRAM block 0.
- R9: The low overlay covers 4000h-7FFFh and the high overlay covers 8000h-BFFFh. A covered access asserts no select at all, except in state 1, where block 0 is selected as usual.
- R10: Port FEh reads the switches in bits 4:0. Port FFh reads {ready, ack, 000b, irq[2:0]}, with the inputs passed through one synchronizing register. Read data appears one clock after the read.
- R11: wait_drive is high for exactly one clock per opcode fetch: the clock after m1 and mreq first go high together.
- R12: row_phase is high for the first clock of a memory access, low for later clocks of that access, and high again once mreq drops.
- R13: Memory selects and dram_ar are registered one clock after the address, are all 0 when mreq is low, and at most one select is active at a time. Default RAM windows give dram_ar equal to A15:A13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Main-processor address |
| cpu_wdata | input | 8 | Write data |
| mreq | input | 1 | Memory cycle |
| iorq | input | 1 | I/O cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| m1 | input | 1 | Opcode fetch marker |
| sub_ready | input | 1 | Sub-processor ready |
| sub_ack | input | 1 | Sub-processor bus acknowledge |
| irq_stat | input | 3 | Interrupt status bits |
| sw_assign | input | 5 | Configuration switches |
| cpu_rdata | output | 8 | Port read data |
| port_sel | output | 1 | Internal port hit |
| sub_rst | output | 1 | Sub-processor reset |
| sub_req | output | 1 | Bus request to sub-processor |
| dram_ar | output | 3 | Mapped DRAM upper address |
| ras_en | output | 4 | Row-strobe enable per DRAM block |
| rom_ipl | output | 1 | Boot ROM select |
| rom_basic | output | 4 | BASIC ROM selects |
| rom_slot | output | 4 | Slot ROM selects |
| com_sel | output | 1 | Shared RAM select |
| row_phase | output | 1 | High in row address phase |
| wait_drive | output | 1 | Drive the wait line active |

## Verification
The decoder is driven with addresses in each 8 KB window under all four system states. Combinations of the 2000h-window select, the high-window bank and the two overlay bits separate the boot, all-RAM and two BASIC maps from each other. Overlay accesses are made both in state 1 and in other states, which shows whether the suppression carries its single exception. Writes to an unassigned port byte, reads of the switch and status ports, and a held three-clock opcode fetch cover the port decode, the synchronizer latency, and the one-shot wait and row/column phase.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    SD_BOOT     = 2'd0,
    SD_RAM      = 2'd1,
    SD_ROMBASIC = 2'd2,
    SD_RAMBASIC = 2'd3
  } sys_state_t;

  localparam logic [5:0] PORT_HI = 6'h3F;
  localparam logic [1:0] P_WIN    = 2'd0;
  localparam logic [1:0] P_STATE  = 2'd1;
  localparam logic [1:0] P_SWITCH = 2'd2;
  localparam logic [1:0] P_STATUS = 2'd3;

  localparam int FD_RUN_BIT = 7;
  localparam int FD_MS_LO   = 4;
  localparam int FC_REQ_BIT = 1;
  localparam int FC_OVL_LO  = 2;
  localparam int FC_OVL_HI  = 3;
  localparam int FC_SEL_LO  = 4;

  localparam logic [4:0] COM_TOP    = 5'h1F;
  localparam logic [2:0] BANKED_WIN = 3'd6;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int SW_W  = 5,
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       io_lo,
  input  logic [7:0]       wdata,
  input  logic             iorq,
  input  logic             rd,
  input  logic             wr,
  input  logic             sub_ready,
  input  logic             sub_ack,
  input  logic [IRQ_W-1:0] irq,
  input  logic [SW_W-1:0]  sw,
  output logic [7:0]       rdata,
  output logic             port_sel,
  output logic [7:0]       fc_q,
  output logic [7:0]       fd_q
);
  logic             hit;
  logic             rdy_s, ack_s;
  logic [IRQ_W-1:0] irq_s;
  logic [7:0]       sw_byte, stat_byte, rd_mux;

  assign hit = iorq && (io_lo[7:2] == PORT_HI);

  always_comb begin
    sw_byte = '0;
    sw_byte[SW_W-1:0] = sw;
    stat_byte = '0;
    stat_byte[7] = rdy_s;
    stat_byte[6] = ack_s;
    stat_byte[IRQ_W-1:0] = irq_s;
    case (io_lo[1:0])
      P_WIN:    rd_mux = fc_q;
      P_STATE:  rd_mux = fd_q;
      P_SWITCH: rd_mux = sw_byte;
      default:  rd_mux = stat_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_s    <= 1'b0;
      ack_s    <= 1'b0;
      irq_s    <= '0;
      fc_q     <= '0;
      fd_q     <= '0;
      rdata    <= '0;
      port_sel <= 1'b0;
    end else begin
      rdy_s    <= sub_ready;
      ack_s    <= sub_ack;
      irq_s    <= irq;
      port_sel <= hit && (rd || wr);
      if (hit && wr) begin
        if (io_lo[1:0] == P_WIN)   fc_q <= wdata;
        if (io_lo[1:0] == P_STATE) fd_q <= wdata;
      end
      rdata <= (hit && rd) ? rd_mux : 8'h00;
    end
  end
endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
#(
  parameter int N_BLK  = 4,
  parameter int N_ROM  = 4,
  parameter int N_SLOT = 4,
  parameter int BANK_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        a_top,
  input  logic              a13,
  input  logic              mreq,
  input  sys_state_t        state,
  input  logic [BANK_W-1:0] bank_hi,
  input  logic [SEL_W-1:0]  win_sel,
  input  logic              ovl_lo,
  input  logic              ovl_hi,
  output logic [2:0]        dram_ar,
  output logic [N_BLK-1:0]  ras_en,
  output logic              rom_ipl,
  output logic [N_ROM-1:0]  rom_basic,
  output logic [N_SLOT-1:0] rom_slot,
  output logic              com_sel
);
  localparam int BLK_IW  = $clog2(N_BLK);
  localparam int SUB_W   = BANK_W - BLK_IW;
  localparam int ROM_IW  = $clog2(N_ROM);
  localparam int SLOT_IW = $clog2(N_SLOT);

  logic [2:0]        win;
  logic [2:0]        nx_ar;
  logic              blk_on, nx_ipl, basic_on, slot_on, nx_com, covered;
  logic [BLK_IW-1:0] blk_idx;
  logic [N_BLK-1:0]  ras_nx;
  logic [N_ROM-1:0]  basic_nx;
  logic [N_SLOT-1:0] slot_nx;

  assign win = a_top[4:2];
  assign covered = (state != SD_RAM) &&
                   ((ovl_lo && win[2:1] == 2'b01) || (ovl_hi && win[2:1] == 2'b10));

  always_comb begin
    nx_ar    = '0;
    blk_on   = 1'b0;
    blk_idx  = '0;
    nx_ipl   = 1'b0;
    basic_on = 1'b0;
    slot_on  = 1'b0;
    nx_com   = 1'b0;
    if (mreq) begin
      if (a_top == COM_TOP) begin
        nx_com = 1'b1;
      end else if (win >= BANKED_WIN) begin
        blk_on  = 1'b1;
        blk_idx = bank_hi[BANK_W-1 -: BLK_IW];
        nx_ar   = {bank_hi[SUB_W-1:0], a13};
      end else if (win == 3'd0 && state == SD_BOOT) begin
        nx_ipl = 1'b1;
      end else if (win == 3'd1 && state == SD_ROMBASIC && !win_sel[SEL_W-1]) begin
        basic_on = 1'b1;
      end else if (win == 3'd1 && win_sel[SEL_W-1] &&
                   (state == SD_ROMBASIC || state == SD_RAMBASIC)) begin
        slot_on = 1'b1;
      end else if (!covered) begin
        blk_on = 1'b1;
        nx_ar  = win;
      end
    end
  end

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    assign ras_nx[g] = blk_on && (blk_idx == BLK_IW'(g));
  end
  for (genvar g = 0; g < N_ROM; g++) begin : g_rom
    assign basic_nx[g] = basic_on && (win_sel[ROM_IW-1:0] == ROM_IW'(g));
  end
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    assign slot_nx[g] = slot_on && (win_sel[SLOT_IW-1:0] == SLOT_IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_ar   <= '0;
      ras_en    <= '0;
      rom_ipl   <= 1'b0;
      rom_basic <= '0;
      rom_slot  <= '0;
      com_sel   <= 1'b0;
    end else begin
      dram_ar   <= nx_ar;
      ras_en    <= ras_nx;
      rom_ipl   <= nx_ipl;
      rom_basic <= basic_nx;
      rom_slot  <= slot_nx;
      com_sel   <= nx_com;
    end
  end
endmodule

// File: rtl/mapper_cycle.sv
module mapper_cycle (
  input  logic clk,
  input  logic rst,
  input  logic mreq,
  input  logic m1,
  output logic wait_drive,
  output logic row_phase
);
  logic fetch, fetch_seen, acc_q;

  assign fetch = m1 && mreq;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_seen <= 1'b0;
      wait_drive <= 1'b0;
      acc_q      <= 1'b0;
      row_phase  <= 1'b1;
    end else begin
      wait_drive <= fetch && !fetch_seen;
      fetch_seen <= fetch;
      acc_q      <= mreq;
      row_phase  <= !(mreq && acc_q);
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int N_BLK  = 4,
  parameter int N_ROM  = 4,
  parameter int N_SLOT = 4,
  parameter int SW_W   = 5,
  parameter int IRQ_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              mreq,
  input  logic              iorq,
  input  logic              rd,
  input  logic              wr,
  input  logic              m1,
  input  logic              sub_ready,
  input  logic              sub_ack,
  input  logic [IRQ_W-1:0]  irq_stat,
  input  logic [SW_W-1:0]   sw_assign,
  output logic [7:0]        cpu_rdata,
  output logic              port_sel,
  output logic              sub_rst,
  output logic              sub_req,
  output logic [2:0]        dram_ar,
  output logic [N_BLK-1:0]  ras_en,
  output logic              rom_ipl,
  output logic [N_ROM-1:0]  rom_basic,
  output logic [N_SLOT-1:0] rom_slot,
  output logic              com_sel,
  output logic              row_phase,
  output logic              wait_drive
);
  logic [7:0] fc_q, fd_q;
  sys_state_t state;
  logic       unused_bits;

  assign state       = sys_state_t'(fd_q[FD_MS_LO +: 2]);
  assign sub_rst     = !fd_q[FD_RUN_BIT];
  assign sub_req     = fc_q[FC_REQ_BIT];
  assign unused_bits = ^{cpu_addr[12], cpu_addr[10:8], fd_q[6], fc_q[7], fc_q[0]};

  mapper_regs #(.SW_W(SW_W), .IRQ_W(IRQ_W)) u_regs (
    .clk(clk), .rst(rst), .io_lo(cpu_addr[7:0]), .wdata(cpu_wdata),
    .iorq(iorq), .rd(rd), .wr(wr), .sub_ready(sub_ready), .sub_ack(sub_ack),
    .irq(irq_stat), .sw(sw_assign), .rdata(cpu_rdata), .port_sel(port_sel),
    .fc_q(fc_q), .fd_q(fd_q)
  );

  mapper_decode #(.N_BLK(N_BLK), .N_ROM(N_ROM), .N_SLOT(N_SLOT), .BANK_W(4), .SEL_W(3)) u_dec (
    .clk(clk), .rst(rst), .a_top(cpu_addr[15:11]), .a13(cpu_addr[13]), .mreq(mreq),
    .state(state), .bank_hi(fd_q[3:0]), .win_sel(fc_q[FC_SEL_LO +: 3]),
    .ovl_lo(fc_q[FC_OVL_LO]), .ovl_hi(fc_q[FC_OVL_HI]),
    .dram_ar(dram_ar), .ras_en(ras_en), .rom_ipl(rom_ipl), .rom_basic(rom_basic),
    .rom_slot(rom_slot), .com_sel(com_sel)
  );

  mapper_cycle u_cyc (
    .clk(clk), .rst(rst), .mreq(mreq), .m1(m1),
    .wait_drive(wait_drive), .row_phase(row_phase)
  );
endmodule

// File: rtl/mapper_chk.sv
module mapper_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] a_top,
  input logic [5:0] a_port,
  input logic       mreq,
  input logic       iorq,
  input logic       rd,
  input logic       wr,
  input logic       m1,
  input logic       port_sel,
  input logic       wait_drive,
  input logic       com_sel,
  input logic       rom_ipl,
  input logic [3:0] rom_basic,
  input logic [3:0] rom_slot,
  input logic [3:0] ras_en,
  input logic       sub_rst,
  input logic [1:0] ms
);
  // R1
  port_hit_chk: assert property (@(posedge clk) disable iff (rst)
    port_sel |-> $past(iorq && (rd || wr) && a_port == 6'h3F));
  // R11
  wait_once_chk: assert property (@(posedge clk) disable iff (rst)
    wait_drive |=> !wait_drive);
  // R11
  wait_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    wait_drive |-> $past(m1 && mreq));
  // R5
  shared_ram_chk: assert property (@(posedge clk) disable iff (rst)
    com_sel |-> $past(mreq && a_top == 5'h1F));
  // R8
  basic_state_chk: assert property (@(posedge clk) disable iff (rst)
    (|rom_basic) |-> $past(ms) == 2'd2);
  // R6
  ipl_state_chk: assert property (@(posedge clk) disable iff (rst)
    rom_ipl |-> $past(ms) == 2'd0);
  // R13
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ras_en, rom_ipl, rom_basic, rom_slot, com_sel}));
  // R2
  reset_halt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sub_rst);
endmodule

bind bank_mapper mapper_chk u_chk (
  .clk(clk), .rst(rst), .a_top(cpu_addr[15:11]), .a_port(cpu_addr[7:2]),
  .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .m1(m1), .port_sel(port_sel),
  .wait_drive(wait_drive), .com_sel(com_sel), .rom_ipl(rom_ipl),
  .rom_basic(rom_basic), .rom_slot(rom_slot), .ras_en(ras_en),
  .sub_rst(sub_rst), .ms(fd_q[5:4])
);

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mreq = 0, iorq = 0, rd = 0, wr = 0, m1 = 0;
  logic        sub_ready = 0, sub_ack = 0;
  logic [2:0]  irq_stat = '0;
  logic [4:0]  sw_assign = '0;
  logic [7:0]  cpu_rdata;
  logic        port_sel, sub_rst, sub_req, com_sel, rom_ipl, row_phase, wait_drive;
  logic [2:0]  dram_ar;
  logic [3:0]  ras_en, rom_basic, rom_slot;

  bank_mapper u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mreq(mreq),
    .iorq(iorq), .rd(rd), .wr(wr), .m1(m1), .sub_ready(sub_ready), .sub_ack(sub_ack),
    .irq_stat(irq_stat), .sw_assign(sw_assign), .cpu_rdata(cpu_rdata),
    .port_sel(port_sel), .sub_rst(sub_rst), .sub_req(sub_req), .dram_ar(dram_ar),
    .ras_en(ras_en), .rom_ipl(rom_ipl), .rom_basic(rom_basic), .rom_slot(rom_slot),
    .com_sel(com_sel), .row_phase(row_phase), .wait_drive(wait_drive)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    logic [31:0] mask;
    string       req;
  } item_t;

  item_t sb[$];
  int    n_chk = 0, n_bad = 0;
  logic [7:0] m_fc = 8'h00, m_fd = 8'h00;
  bit    done = 0;

  // monitor: pops one expected item per falling edge and compares
  initial forever begin
    @(negedge clk);
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] obs;
      it = sb.pop_front();
      case (it.kind)
        0:       obs = {15'b0, dram_ar, ras_en, rom_ipl, rom_basic, rom_slot, com_sel};
        1:       obs = {24'b0, cpu_rdata};
        default: obs = {27'b0, sub_rst, sub_req, port_sel, wait_drive, row_phase};
      endcase
      n_chk++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: kind %0d actual %h expected %h", it.req, it.kind,
                 obs & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int kind, input logic [31:0] exp, input logic [31:0] mask,
                      input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  function automatic logic [16:0] exp_map(input logic [15:0] a);
    logic [2:0] ar;
    logic [3:0] ras, bas, slt;
    logic       ipl, com;
    int         w, ms;
    ar = '0; ras = '0; bas = '0; slt = '0; ipl = 0; com = 0;
    w  = int'(a[15:13]);
    ms = int'(m_fd[5:4]);
    if (a[15:11] == 5'h1F) com = 1;
    else if (w >= 6) begin ras[m_fd[3:2]] = 1'b1; ar = {m_fd[1:0], a[13]}; end
    else if (w == 0 && ms == 0) ipl = 1;
    else if (w == 1 && ms == 2) begin
      if (m_fc[6]) slt[m_fc[5:4]] = 1'b1; else bas[m_fc[5:4]] = 1'b1;
    end
    else if (w == 1 && ms == 3 && m_fc[6]) slt[m_fc[5:4]] = 1'b1;
    else if (ms != 1 && ((m_fc[2] && (w == 2 || w == 3)) || (m_fc[3] && (w == 4 || w == 5)))) begin
      ar = '0;
    end
    else begin ras[0] = 1'b1; ar = 3'(w); end
    return {ar, ras, ipl, bas, slt, com};
  endfunction

  task automatic io_wr(input logic [7:0] a, input logic [7:0] d);
    cpu_addr = {8'h00, a}; cpu_wdata = d; iorq = 1; wr = 1;
    tick();
    iorq = 0; wr = 0;
    if (a == 8'hFC) m_fc = d;
    if (a == 8'hFD) m_fd = d;
  endtask

  task automatic io_rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    cpu_addr = {8'h00, a}; iorq = 1; rd = 1;
    tick();
    push(1, {24'b0, exp}, 32'hFF, req);
    iorq = 0; rd = 0;
  endtask

  task automatic mem_chk(input logic [15:0] a, input string req);
    cpu_addr = a; mreq = 1; rd = 1;
    tick();
    push(0, {15'b0, exp_map(a)}, 32'h1FFFF, req);
    mreq = 0; rd = 0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R2 reset state
    push(2, 32'b10001, 32'h1F, "R2");
    push(0, 32'h0, 32'h1FFFF, "R2");
    io_rd_chk(8'hFD, 8'h00, "R2");
    io_rd_chk(8'hFC, 8'h00, "R2");
    // boot map
    mem_chk(16'h0123, "R6");
    mem_chk(16'h4100, "R6");
    mem_chk(16'hFA00, "R5");
    // write to a foreign port is ignored
    io_wr(8'hF9, 8'hFF);
    io_rd_chk(8'hFD, 8'h00, "R1");
    io_rd_chk(8'hFC, 8'h00, "R1");
    cpu_addr = 16'h00FB; iorq = 1; rd = 1; tick();
    push(2, 32'b00000, 32'b00100, "R1");
    cpu_addr = 16'h00FE; tick();
    push(2, 32'b00100, 32'b00100, "R1");
    iorq = 0; rd = 0; tick();
    // sub-processor controls
    io_wr(8'hFD, 8'h80);
    push(2, 32'b00000, 32'b10000, "R3");
    io_rd_chk(8'hFD, 8'h80, "R3");
    io_wr(8'hFC, 8'h02);
    push(2, 32'b01000, 32'b01000, "R4");
    // all-RAM state with high-window bank 1011b
    io_wr(8'hFD, 8'h9B);
    mem_chk(16'hC000, "R7");
    mem_chk(16'hE100, "R7");
    mem_chk(16'hF900, "R5");
    mem_chk(16'h0000, "R6");
    // overlays
    io_wr(8'hFC, 8'h0E);
    mem_chk(16'h4000, "R9");
    io_wr(8'hFD, 8'hA0);
    mem_chk(16'h5000, "R9");
    mem_chk(16'h9000, "R9");
    mem_chk(16'hC000, "R7");
    // 2000h window
    io_wr(8'hFC, 8'h12);
    mem_chk(16'h2000, "R8");
    io_wr(8'hFC, 8'h62);
    mem_chk(16'h2800, "R8");
    io_wr(8'hFD, 8'hB0);
    mem_chk(16'h3000, "R8");
    io_wr(8'hFC, 8'h22);
    mem_chk(16'h2000, "R8");
    io_wr(8'hFC, 8'h0A);
    mem_chk(16'h8000, "R9");
    mem_chk(16'h4000, "R9");
    mem_chk(16'h0000, "R6");
    // idle bus
    cpu_addr = 16'h4000; tick();
    push(0, 32'h0, 32'h1FFFF, "R13");
    // switch and status ports
    sw_assign = 5'h15;
    io_rd_chk(8'hFE, 8'h15, "R10");
    sub_ready = 1; sub_ack = 0; irq_stat = 3'b101;
    tick();
    io_rd_chk(8'hFF, 8'h85, "R10");
    // opcode fetch wait and row phase
    cpu_addr = 16'h4000; m1 = 1; mreq = 1; rd = 1;
    tick();
    push(2, 32'b00011, 32'b00011, "R11");
    tick();
    push(2, 32'b00000, 32'b00011, "R12");
    tick();
    push(2, 32'b00000, 32'b00011, "R11");
    m1 = 0; mreq = 0; rd = 0;
    tick();
    push(2, 32'b00001, 32'b00011, "R12");
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule